// File: doc/BRIEF.md
# Floating-Point Compare and Exception Status Unit

This block holds the floating-point status word of a processor. It records the outcome of every floating-point operation. The arithmetic datapath and the comparator live elsewhere and hand this unit their results.

For an arithmetic result the unit receives five IEEE exception flags. It latches them as the current exceptions and tests them against the trap-enable mask. If no enabled flag is raised, it folds them into a sticky accrued field. For a compare it receives a relation code, a selector naming one of four condition-code fields, and a flag that marks the signalling form. It then writes the selected field, or raises an invalid-operation trap when the operands are unordered and that case must trap.

A trap is reported as a one-cycle request together with a trap-type code. Software reads and writes the whole status word through a plain write-enable and data port. The rounding-mode field is brought out on its own output.

Top module: `fsu_status`

## Requirements
- R1: After a synchronous active-low reset, the status word reads all zeros, trap_req is 0 and trap_type is 0.
- R2: When sw_we is high at a clock edge, the status word takes sw_wdata on that edge, and no trap is raised. An operation presented in the same cycle is discarded.
- R3: rnd_mode always shows status bits 31:30, with this meaning: 0 is round to nearest-even, 1 is round toward zero, 2 is round toward +infinity, 3 is round toward -infinity.
- R4: An arithmetic operation (op_valid=1, op_cmp=0) replaces the current-exception field, bits 4:0, with ieee_flags. The flag order is bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero, bit 0 inexact.
- R5: An arithmetic operation traps when ieee_flags AND the trap-enable mask is nonzero. The mask is status bits 27:23, aligned to the flags by a right shift of 23. A trap shows up in the cycle after the operation as follows:
  - trap_req is 1 for exactly that one cycle;
  - trap_type equals the parameter TT_FP_EXC, and is 0 whenever trap_req is 0;
  - the trap-type field, status bits 16:14, reads 1.
- R6: The accrued field, bits 9:5, is ORed with the operation's flags only when the operation does not trap. It is never cleared except by a software write.
- R7: A compare (op_valid=1, op_cmp=1) that does not trap writes a 2-bit condition-code field and leaves every other field unchanged.
  - The field is chosen by cc_sel: 0 gives bits 11:10, 1 gives bits 33:32, 2 gives bits 35:34, 3 gives bits 37:36.
  - The value comes from cmp_rel: 0 (equal) writes 00, 1 (less) writes 01, 2 (greater) writes 10, 3 (unordered) writes 11.
  - An ordered compare never traps, whatever cmp_signal says.
- R8: An unordered compare traps when cmp_signal is 1 or the invalid trap-enable bit 27 is 1. The trap follows the R5 pattern and also sets the current invalid bit 4. No condition-code field is written.
- R9: An unordered compare that does not trap writes 11 to its field, sets accrued invalid bit 9, and leaves the current-exception field unchanged.
- R10: In a cycle with neither op_valid nor sw_we, the status word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_we | input | 1 | Software write enable for the whole status word |
| sw_wdata | input | STAT_W (38) | Software write data |
| op_valid | input | 1 | An operation result is presented this cycle |
| op_cmp | input | 1 | 1 means compare, 0 means arithmetic |
| cmp_rel | input | 2 | Compare relation: 0 equal, 1 less, 2 greater, 3 unordered |
| cc_sel | input | 2 | Condition-code field selector for a compare |
| cmp_signal | input | 1 | Signalling compare: unordered always traps |
| ieee_flags | input | NFLAG (5) | IEEE flags of an arithmetic result |
| stat_q | output | STAT_W (38) | Status word read-back |
| rnd_mode | output | 2 | Rounding mode field |
| trap_req | output | 1 | One-cycle floating-point trap request |
| trap_type | output | TT_W | Trap-type code while trap_req is high, else 0 |

## Verification
The bench builds the unit with TT_W at its default of 9 and overrides TT_FP_EXC with 9'h0A5. A trap_type that is hard-wired, or that ignores its parameter, therefore fails the trap checks. The status-word layout is fixed by the package, so all four condition-code fields sit where the bench can preload them with software writes. The bench drives every relation code and every selector, and both trap causes of an unordered compare.

// File: rtl/fsu_pkg.sv
// fsu_pkg: field layout and shared types of the floating-point status word.
// Assumes a single status word; every field position is derived here.
package fsu_pkg;
    localparam int NFLAG    = 5;
    localparam int FL_NX    = 0;
    localparam int FL_DZ    = 1;
    localparam int FL_UF    = 2;
    localparam int FL_OF    = 3;
    localparam int FL_NV    = 4;
    localparam int CEXC_LSB = 0;
    localparam int AEXC_LSB = CEXC_LSB + NFLAG;
    localparam int CC_W     = 2;
    localparam int NCC      = 4;
    localparam int CC_BASE  = 10;
    localparam int CC_STEP0 = 20;
    localparam int FTT_LSB  = 14;
    localparam int FTT_W    = 3;
    localparam int TEM_LSB  = 23;
    localparam int RND_LSB  = 30;
    localparam int RND_W    = 2;
    localparam int SEL_W    = $clog2(NCC);
    localparam int STAT_W   = CC_BASE + CC_STEP0 + CC_W * (NCC - 1) + CC_W;
    localparam logic [FTT_W-1:0] FTT_IEEE = 3'd1;

    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef enum logic [RND_W-1:0] {
        RND_NEAR = 2'd0,
        RND_ZERO = 2'd1,
        RND_PINF = 2'd2,
        RND_NINF = 2'd3
    } rnd_e;

    // Lowest bit of condition-code field sel (offsets 0, 22, 24, 26 from base).
    function automatic int cc_lsb(input int sel);
        return (sel == 0) ? CC_BASE : CC_BASE + CC_STEP0 + CC_W * sel;
    endfunction
endpackage

// File: rtl/fsu_exc_eval.sv
// fsu_exc_eval: next status word for an arithmetic result.
// Assumes the flags are valid whenever the caller selects this path.
module fsu_exc_eval
    import fsu_pkg::*;
(
    input  logic [STAT_W-1:0] stat_cur,
    input  logic [NFLAG-1:0]  flags,
    output logic [STAT_W-1:0] stat_nxt,
    output logic              trap
);
    logic [NFLAG-1:0] tem;
    logic [NFLAG-1:0] hit;

    // Align the enable mask to the flags and find enabled exceptions.
    always_comb begin
        tem  = stat_cur[TEM_LSB +: NFLAG];
        hit  = flags & tem;
        trap = |hit;
    end

    // Build the updated word: current flags always, accrue or trap code.
    always_comb begin
        stat_nxt = stat_cur;
        stat_nxt[CEXC_LSB +: NFLAG] = flags;
        if (trap) begin
            stat_nxt[FTT_LSB +: FTT_W] = FTT_IEEE;
        end else begin
            stat_nxt[AEXC_LSB +: NFLAG] = stat_cur[AEXC_LSB +: NFLAG] | flags;
        end
    end
endmodule

// File: rtl/fsu_cmp_eval.sv
// fsu_cmp_eval: next status word for a compare result.
// Assumes the relation comes from an external comparator; a trapping
// unordered compare leaves every condition-code field as it was.
module fsu_cmp_eval
    import fsu_pkg::*;
(
    input  logic [STAT_W-1:0] stat_cur,
    input  logic [1:0]        rel,
    input  logic [SEL_W-1:0]  sel,
    input  logic              signal_cmp,
    output logic [STAT_W-1:0] stat_nxt,
    output logic              trap
);
    logic              unord;
    logic [CC_W-1:0]   code;
    logic [NCC-1:0]    sel_hot;
    logic [CC_W-1:0]   fld_next [NCC];

    // Classify the relation and decide whether it must trap.
    always_comb begin
        unord = (rel == REL_UN);
        code  = rel;
        trap  = unord && (signal_cmp || stat_cur[TEM_LSB + FL_NV]);
    end

    // One lane per condition-code field: keep it or load the new code.
    for (genvar i = 0; i < NCC; i++) begin : g_cc
        localparam int LSB = cc_lsb(i);
        assign sel_hot[i]  = (sel == SEL_W'(i));
        assign fld_next[i] = (sel_hot[i] && !trap) ? code : stat_cur[LSB +: CC_W];
    end

    // Merge the lanes and the exception side effects into the new word.
    always_comb begin
        stat_nxt = stat_cur;
        for (int i = 0; i < NCC; i++) begin
            stat_nxt[cc_lsb(i) +: CC_W] = fld_next[i];
        end
        if (trap) begin
            stat_nxt[CEXC_LSB + FL_NV] = 1'b1;
            stat_nxt[FTT_LSB +: FTT_W] = FTT_IEEE;
        end else if (unord) begin
            stat_nxt[AEXC_LSB + FL_NV] = 1'b1;
        end
    end
endmodule

// File: rtl/fsu_status.sv
// fsu_status: floating-point status word with compare condition codes,
// exception accrual and a registered one-cycle trap request.
// Assumes at most one operation per cycle; a software write wins.
module fsu_status
    import fsu_pkg::*;
#(
    parameter int              TT_W      = 9,
    parameter logic [TT_W-1:0] TT_FP_EXC = 9'h021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [STAT_W-1:0] sw_wdata,
    input  logic              op_valid,
    input  logic              op_cmp,
    input  logic [1:0]        cmp_rel,
    input  logic [SEL_W-1:0]  cc_sel,
    input  logic              cmp_signal,
    input  logic [NFLAG-1:0]  ieee_flags,
    output logic [STAT_W-1:0] stat_q,
    output logic [RND_W-1:0]  rnd_mode,
    output logic              trap_req,
    output logic [TT_W-1:0]   trap_type
);
    logic [STAT_W-1:0] exc_nxt;
    logic [STAT_W-1:0] cmp_nxt;
    logic              exc_trap;
    logic              cmp_trap;
    logic [STAT_W-1:0] op_nxt;
    logic              op_trap;
    rnd_e              rnd_dec;

    fsu_exc_eval u_exc (
        .stat_cur (stat_q),
        .flags    (ieee_flags),
        .stat_nxt (exc_nxt),
        .trap     (exc_trap)
    );

    fsu_cmp_eval u_cmp (
        .stat_cur   (stat_q),
        .rel        (cmp_rel),
        .sel        (cc_sel),
        .signal_cmp (cmp_signal),
        .stat_nxt   (cmp_nxt),
        .trap       (cmp_trap)
    );

    // Pick the result path of the presented operation.
    always_comb begin
        op_nxt  = op_cmp ? cmp_nxt  : exc_nxt;
        op_trap = op_cmp ? cmp_trap : exc_trap;
    end

    // Status word and trap outputs; software write has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q    <= '0;
            trap_req  <= 1'b0;
            trap_type <= '0;
        end else begin
            trap_req  <= 1'b0;
            trap_type <= '0;
            if (sw_we) begin
                stat_q <= sw_wdata;
            end else if (op_valid) begin
                stat_q    <= op_nxt;
                trap_req  <= op_trap;
                trap_type <= op_trap ? TT_FP_EXC : '0;
            end
        end
    end

    // Rounding field decode.
    always_comb begin
        rnd_dec  = rnd_e'(stat_q[RND_LSB +: RND_W]);
        rnd_mode = rnd_dec;
    end
endmodule

// File: rtl/fsu_status_chk.sv
// fsu_status_chk: temporal properties of fsu_status, attached by bind.
// Assumes the reset is held for at least one clock edge.
module fsu_status_chk
    import fsu_pkg::*;
#(
    parameter int              TT_W      = 9,
    parameter logic [TT_W-1:0] TT_FP_EXC = 9'h021
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_we,
    input logic [STAT_W-1:0] sw_wdata,
    input logic              op_valid,
    input logic              op_cmp,
    input logic [1:0]        cmp_rel,
    input logic              cmp_signal,
    input logic [STAT_W-1:0] stat_q,
    input logic              trap_req,
    input logic [TT_W-1:0]   trap_type
);
    logic [CC_W*NCC-1:0] cc_all;

    // Gather every condition-code field for the no-write check.
    for (genvar i = 0; i < NCC; i++) begin : g_cc
        assign cc_all[i*CC_W +: CC_W] = stat_q[cc_lsb(i) +: CC_W];
    end

    a_r2_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sw_we) |-> (stat_q == $past(sw_wdata)) && !trap_req);

    a_r5_trap_from_op: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(op_valid && !sw_we));

    a_r5_trap_ftt: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (stat_q[FTT_LSB +: FTT_W] == FTT_IEEE));

    a_r5_type_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (trap_type == TT_FP_EXC));

    a_r5_type_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |-> (trap_type == '0));

    a_r6_accrued_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sw_we) |-> (($past(stat_q[AEXC_LSB +: NFLAG]) & ~stat_q[AEXC_LSB +: NFLAG]) == '0));

    a_r8_trap_keeps_cc: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && $past(op_cmp)) |-> (cc_all == $past(cc_all)));

    a_r9_quiet_unordered: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid && op_cmp && !sw_we && (cmp_rel == 2'd3) && !cmp_signal
              && !stat_q[TEM_LSB + FL_NV])
        |-> !trap_req && stat_q[AEXC_LSB + FL_NV]);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!op_valid && !sw_we) |-> $stable(stat_q));
endmodule

bind fsu_status fsu_status_chk #(
    .TT_W      (TT_W),
    .TT_FP_EXC (TT_FP_EXC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_we      (sw_we),
    .sw_wdata   (sw_wdata),
    .op_valid   (op_valid),
    .op_cmp     (op_cmp),
    .cmp_rel    (cmp_rel),
    .cmp_signal (cmp_signal),
    .stat_q     (stat_q),
    .trap_req   (trap_req),
    .trap_type  (trap_type)
);

// File: tb/fsu_status_tb.sv
`timescale 1ns/1ps
// fsu_status_tb: directed scenarios, one task each, checked at the ports.
module fsu_status_tb;
    localparam int          TT_W  = 9;
    localparam logic [8:0]  TT_EXP = 9'h0A5;
    localparam int          SW    = 38;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_we = 1'b0;
    logic [SW-1:0] sw_wdata = '0;
    logic          op_valid = 1'b0;
    logic          op_cmp = 1'b0;
    logic [1:0]    cmp_rel = '0;
    logic [1:0]    cc_sel = '0;
    logic          cmp_signal = 1'b0;
    logic [4:0]    ieee_flags = '0;
    logic [SW-1:0] stat_q;
    logic [1:0]    rnd_mode;
    logic          trap_req;
    logic [TT_W-1:0] trap_type;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fsu_status #(.TT_W(TT_W), .TT_FP_EXC(TT_EXP)) u_dut (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .op_valid(op_valid), .op_cmp(op_cmp), .cmp_rel(cmp_rel),
        .cc_sel(cc_sel), .cmp_signal(cmp_signal), .ieee_flags(ieee_flags),
        .stat_q(stat_q), .rnd_mode(rnd_mode), .trap_req(trap_req),
        .trap_type(trap_type)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sw_write(input logic [SW-1:0] v);
        sw_we = 1'b1; sw_wdata = v;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic arith(input logic [4:0] f);
        op_valid = 1'b1; op_cmp = 1'b0; ieee_flags = f;
        @(negedge clk);
        op_valid = 1'b0; ieee_flags = '0;
    endtask

    task automatic cmp(input logic [1:0] rel, input logic [1:0] sel, input logic sig);
        op_valid = 1'b1; op_cmp = 1'b1; cmp_rel = rel; cc_sel = sel; cmp_signal = sig;
        @(negedge clk);
        op_valid = 1'b0; op_cmp = 1'b0; cmp_signal = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 status", 64'(stat_q), 64'h0);
        chk("R1 trap_req", 64'(trap_req), 64'h0);
        chk("R1 trap_type", 64'(trap_type), 64'h0);
    endtask

    task automatic t_round();
        for (int m = 0; m < 4; m++) begin
            sw_write(SW'(m) << 30);
            chk("R2 readback", 64'(stat_q), 64'(SW'(m) << 30));
            chk("R3 rnd_mode", 64'(rnd_mode), 64'(m));
        end
    endtask

    task automatic t_arith_accrue();
        sw_write('0);
        arith(5'b01001);
        chk("R4 cexc", 64'(stat_q[4:0]), 64'h09);
        chk("R6 aexc", 64'(stat_q[9:5]), 64'h09);
        chk("R5 no trap", 64'(trap_req), 64'h0);
        arith(5'b00010);
        chk("R4 cexc replace", 64'(stat_q[4:0]), 64'h02);
        chk("R6 aexc sticky", 64'(stat_q[9:5]), 64'h0B);
    endtask

    task automatic t_arith_trap();
        sw_write((SW'(1) << 26) | (SW'(1) << 5));
        arith(5'b01001);
        chk("R5 trap_req", 64'(trap_req), 64'h1);
        chk("R5 trap_type", 64'(trap_type), 64'(TT_EXP));
        chk("R5 ftt", 64'(stat_q[16:14]), 64'h1);
        chk("R4 cexc on trap", 64'(stat_q[4:0]), 64'h09);
        chk("R6 aexc on trap", 64'(stat_q[9:5]), 64'h01);
        @(negedge clk);
        chk("R5 pulse ends", 64'(trap_req), 64'h0);
        chk("R5 type clears", 64'(trap_type), 64'h0);
    endtask

    task automatic t_arith_masked();
        sw_write(SW'(1) << 27);
        arith(5'b00001);
        chk("R5 masked no trap", 64'(trap_req), 64'h0);
        chk("R6 masked accrue", 64'(stat_q[9:5]), 64'h01);
    endtask

    task automatic t_cmp_codes();
        sw_write('0);
        cmp(2'd1, 2'd0, 1'b1);
        chk("R7 less sel0", 64'(stat_q), 64'h400);
        chk("R7 ordered signalling", 64'(trap_req), 64'h0);
        cmp(2'd2, 2'd1, 1'b0);
        chk("R7 greater sel1", 64'(stat_q), 64'(SW'('h400) | (SW'(2) << 32)));
        sw_write((SW'(3) << 34) | (SW'(3) << 10));
        cmp(2'd0, 2'd2, 1'b0);
        chk("R7 equal clears sel2", 64'(stat_q), 64'(SW'(3) << 10));
        cmp(2'd3, 2'd3, 1'b0);
        chk("R9 quiet unordered", 64'(stat_q),
            64'((SW'(3) << 10) | (SW'(3) << 36) | (SW'(1) << 9)));
        chk("R9 no trap", 64'(trap_req), 64'h0);
    endtask

    task automatic t_cmp_trap_sig();
        sw_write((SW'(1) << 10) | (SW'(2) << 32));
        cmp(2'd3, 2'd0, 1'b1);
        chk("R8 signalling trap", 64'(trap_req), 64'h1);
        chk("R8 trap_type", 64'(trap_type), 64'(TT_EXP));
        chk("R8 word", 64'(stat_q),
            64'((SW'(1) << 10) | (SW'(2) << 32) | (SW'(1) << 4) | (SW'(1) << 14)));
    endtask

    task automatic t_cmp_trap_tem();
        sw_write(SW'(1) << 27);
        cmp(2'd3, 2'd1, 1'b0);
        chk("R8 enabled trap", 64'(trap_req), 64'h1);
        chk("R8 enabled word", 64'(stat_q),
            64'((SW'(1) << 27) | (SW'(1) << 4) | (SW'(1) << 14)));
    endtask

    task automatic t_priority();
        sw_write('0);
        sw_we = 1'b1; sw_wdata = SW'(5'h1F) << 23;
        op_valid = 1'b1; op_cmp = 1'b0; ieee_flags = 5'h1F;
        @(negedge clk);
        sw_we = 1'b0; op_valid = 1'b0; ieee_flags = '0;
        chk("R2 write wins", 64'(stat_q), 64'(SW'(5'h1F) << 23));
        chk("R2 op dropped", 64'(trap_req), 64'h0);
    endtask

    task automatic t_hold();
        sw_write(SW'(38'h2A_5A5A_5A5A));
        ieee_flags = 5'h1F; cmp_rel = 2'd3;
        repeat (3) @(negedge clk);
        ieee_flags = '0;
        chk("R10 hold", 64'(stat_q), 64'h2A_5A5A_5A5A);
        chk("R10 no trap", 64'(trap_req), 64'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_round();
        t_arith_accrue();
        t_arith_trap();
        t_arith_masked();
        t_cmp_codes();
        t_cmp_trap_sig();
        t_cmp_trap_tem();
        t_priority();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule